// File: doc/BRIEF.md
# Task Register Load Checker

This block sits between the descriptor fetch stage and the task register of a processor core. When the core executes a load of the task register, the fetch stage supplies a 16-bit selector together with the system descriptor it has already read from the global table, split into fields: type, system/segment flag, present flag, limit, base and privilege level. The block also receives a flag that marks a failed descriptor fetch. It checks the request and returns either a fault code or a commit.

The checks run in a fixed priority order, and only the first one that fails is reported. A fault carries the selector's table index as its error value. When every check passes, the block drives a write-back strobe, so the caller can store the descriptor back with its busy bit set. On the same edge it loads the task register and its descriptor cache. The block does not fetch descriptors from memory or dispatch faults; the surrounding core does both.

Top module: `tr_load_check`

## Requirements
- R1: A request with `fetch_err` high reports fault code 1 (general protection), whatever the other inputs hold.
- R2: A request whose selector bit 2 (local-table indicator) is set reports fault code 1 unless R1 applies first.
- R3: A request whose descriptor `desc_s` flag is 1 (code/data descriptor) reports fault code 1 unless R1 or R2 applies first.
- R4: Only type 4'h1 (available 16-bit task state) and type 4'h9 (available 32-bit task state) are accepted. Any other type reports fault code 1 unless an earlier check applies.
- R5: For type 4'h1, a limit below 0x2B reports fault code 2 (invalid task state). A limit of exactly 0x2B passes this check.
- R6: For type 4'h9, a limit below 0x67 reports fault code 2. A limit of exactly 0x67 passes this check.
- R7: The present flag is examined only after the type and limit checks. If it is 0, fault code 3 (not present) is reported. A type or limit fault takes precedence over a clear present flag.
- R8: On every completed request, `fault_err` equals selector bits 15:3 (the table index), whether or not a fault is reported.
- R9: On success, fault code 0 is reported and `wb_valid` pulses with `wb_type` equal to the descriptor type with bit 1 (busy) set. On the same edge, the task register takes the selector, and the cache takes the busy type, base, limit and DPL.
- R10: `done` pulses for exactly one cycle, one cycle after each request. When no result is due, `done` and `wb_valid` are 0 and the fault code is 0.
- R11: On any fault, `wb_valid` stays 0 and the task register and cache keep their previous contents.
- R12: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A load request is presented this cycle |
| req_sel | input | 16 | Selector to load |
| fetch_err | input | 1 | The descriptor fetch for this selector failed |
| desc_type | input | 4 | Descriptor type field |
| desc_s | input | 1 | 1 = code/data descriptor, 0 = system descriptor |
| desc_p | input | 1 | Descriptor present flag |
| desc_limit | input | 20 | Descriptor limit |
| desc_base | input | 32 | Descriptor base |
| desc_dpl | input | 2 | Descriptor privilege level |
| done | output | 1 | Result valid, one-cycle pulse |
| fault_code | output | 2 | 0 none, 1 general protection, 2 invalid task state, 3 not present |
| fault_err | output | 13 | Error value: selector index |
| wb_valid | output | 1 | Write the busy descriptor back |
| wb_type | output | 4 | Type to write back (busy bit set) |
| tr_sel | output | 16 | Task register selector |
| tr_type | output | 4 | Cached descriptor type |
| tr_base | output | 32 | Cached descriptor base |
| tr_limit | output | 20 | Cached descriptor limit |
| tr_dpl | output | 2 | Cached descriptor privilege level |

## Verification
All of the block's results appear in the cycle after the edge that samples a request. That edge loads the done, fault code, error value and write-back outputs, and it also updates the task register and cache, so nothing is due in a later cycle. The bench's reference model takes the same edge and computes its expectation from the sampled inputs. The bench compares every output at the falling edge that follows, which keeps each comparison aligned to that one-cycle latency. Idle cycles between requests are compared as well, so any stray pulse or change of the task register is reported.

// File: rtl/tr_load_pkg.sv
package tr_load_pkg;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_GP   = 2'd1,
    FLT_TS   = 2'd2,
    FLT_NP   = 2'd3
  } fault_e;

  localparam int          TYPE_W      = 4;
  localparam logic [3:0]  TYPE_TSS16  = 4'h1;
  localparam logic [3:0]  TYPE_TSS32  = 4'h9;
  localparam int          BUSY_BIT    = 1;
  localparam int          TI_BIT      = 2;
  localparam int          IDX_LSB     = 3;
  localparam int          MIN_LIM16   = 'h2B;
  localparam int          MIN_LIM32   = 'h67;

endpackage

// File: rtl/tr_gate_check.sv
module tr_gate_check
  import tr_load_pkg::*;
#(
  parameter int SEL_W = 16
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic              fetch_err,
  input  logic              desc_s,
  input  logic [TYPE_W-1:0] desc_type,
  output logic              gp_hit,
  output logic              is_tss16,
  output logic              is_tss32
);

  logic ti_local;
  logic bad_type;

  always_comb begin
    ti_local = sel[TI_BIT];
    is_tss16 = (desc_type == TYPE_TSS16);
    is_tss32 = (desc_type == TYPE_TSS32);
    bad_type = !(is_tss16 || is_tss32);
    gp_hit   = fetch_err || ti_local || desc_s || bad_type;
  end

endmodule

// File: rtl/tr_limit_check.sv
module tr_limit_check
  import tr_load_pkg::*;
#(
  parameter int LIMIT_W = 20
) (
  input  logic               is_tss16,
  input  logic               is_tss32,
  input  logic [LIMIT_W-1:0] limit,
  output logic               too_short
);

  localparam int NUM_FMT = 2;
  localparam logic [LIMIT_W-1:0] MIN16 = LIMIT_W'(MIN_LIM16);
  localparam logic [LIMIT_W-1:0] MIN32 = LIMIT_W'(MIN_LIM32);

  logic [NUM_FMT-1:0] fmt_sel;
  logic [NUM_FMT-1:0] fmt_short;

  assign fmt_sel = {is_tss32, is_tss16};

  for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
    localparam logic [LIMIT_W-1:0] MIN_V = (g == 0) ? MIN16 : MIN32;
    assign fmt_short[g] = fmt_sel[g] && (limit < MIN_V);
  end

  assign too_short = |fmt_short;

endmodule

// File: rtl/tr_fault_prio.sv
module tr_fault_prio
  import tr_load_pkg::*;
(
  input  logic   gp_hit,
  input  logic   ts_hit,
  input  logic   present,
  output fault_e fault
);

  always_comb begin
    if (gp_hit)        fault = FLT_GP;
    else if (ts_hit)   fault = FLT_TS;
    else if (!present) fault = FLT_NP;
    else               fault = FLT_NONE;
  end

endmodule

// File: rtl/tr_load_check.sv
module tr_load_check
  import tr_load_pkg::*;
#(
  parameter int SEL_W   = 16,
  parameter int LIMIT_W = 20,
  parameter int BASE_W  = 32,
  parameter int DPL_W   = 2,
  localparam int IDX_W  = SEL_W - IDX_LSB
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [SEL_W-1:0]   req_sel,
  input  logic               fetch_err,
  input  logic [3:0]         desc_type,
  input  logic               desc_s,
  input  logic               desc_p,
  input  logic [LIMIT_W-1:0] desc_limit,
  input  logic [BASE_W-1:0]  desc_base,
  input  logic [DPL_W-1:0]   desc_dpl,
  output logic               done,
  output logic [1:0]         fault_code,
  output logic [IDX_W-1:0]   fault_err,
  output logic               wb_valid,
  output logic [3:0]         wb_type,
  output logic [SEL_W-1:0]   tr_sel,
  output logic [3:0]         tr_type,
  output logic [BASE_W-1:0]  tr_base,
  output logic [LIMIT_W-1:0] tr_limit,
  output logic [DPL_W-1:0]   tr_dpl
);

  logic   gp_hit, is16, is32, ts_hit;
  fault_e fault_nx;
  logic   commit;
  logic [3:0] busy_type;

  logic               done_nx, wb_nx;
  logic [1:0]         code_nx;
  logic [IDX_W-1:0]   err_nx;
  logic [3:0]         wbt_nx;

  tr_gate_check #(.SEL_W(SEL_W)) u_gate (
    .sel       (req_sel),
    .fetch_err (fetch_err),
    .desc_s    (desc_s),
    .desc_type (desc_type),
    .gp_hit    (gp_hit),
    .is_tss16  (is16),
    .is_tss32  (is32)
  );

  tr_limit_check #(.LIMIT_W(LIMIT_W)) u_limit (
    .is_tss16  (is16),
    .is_tss32  (is32),
    .limit     (desc_limit),
    .too_short (ts_hit)
  );

  tr_fault_prio u_prio (
    .gp_hit  (gp_hit),
    .ts_hit  (ts_hit),
    .present (desc_p),
    .fault   (fault_nx)
  );

  always_comb begin
    busy_type           = desc_type;
    busy_type[BUSY_BIT] = 1'b1;
    commit              = req_valid && (fault_nx == FLT_NONE);
    done_nx             = req_valid;
    code_nx             = req_valid ? 2'(fault_nx) : 2'd0;
    err_nx              = req_valid ? req_sel[SEL_W-1:IDX_LSB] : '0;
    wb_nx               = commit;
    wbt_nx              = commit ? busy_type : 4'h0;
  end

  // result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done       <= 1'b0;
      fault_code <= 2'd0;
      fault_err  <= '0;
      wb_valid   <= 1'b0;
      wb_type    <= 4'h0;
    end else begin
      done       <= done_nx;
      fault_code <= code_nx;
      fault_err  <= err_nx;
      wb_valid   <= wb_nx;
      wb_type    <= wbt_nx;
    end
  end

  // task register and descriptor cache, enabled on commit only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tr_sel   <= '0;
      tr_type  <= 4'h0;
      tr_base  <= '0;
      tr_limit <= '0;
      tr_dpl   <= '0;
    end else if (commit) begin
      tr_sel   <= req_sel;
      tr_type  <= busy_type;
      tr_base  <= desc_base;
      tr_limit <= desc_limit;
      tr_dpl   <= desc_dpl;
    end
  end

endmodule

// File: rtl/tr_load_check_sva.sv
module tr_load_check_sva #(
  parameter int SEL_W   = 16,
  parameter int LIMIT_W = 20,
  parameter int IDX_W   = 13
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [SEL_W-1:0]   req_sel,
  input logic               fetch_err,
  input logic [3:0]         desc_type,
  input logic               desc_s,
  input logic               desc_p,
  input logic [LIMIT_W-1:0] desc_limit,
  input logic               done,
  input logic [1:0]         fault_code,
  input logic [IDX_W-1:0]   fault_err,
  input logic               wb_valid,
  input logic [3:0]         wb_type,
  input logic [SEL_W-1:0]   tr_sel,
  input logic [3:0]         tr_type
);

  a_r10_done_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> done);

  a_r10_no_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!done && !wb_valid && fault_code == 2'd0));

  a_r1_fetch_gp: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && fetch_err) |=> (fault_code == 2'd1));

  a_r2_local_gp: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_sel[2]) |=> (fault_code == 2'd1));

  a_r3_seg_gp: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && desc_s) |=> (fault_code == 2'd1));

  a_r7_np: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !fetch_err && !req_sel[2] && !desc_s && desc_type == 4'h9
     && desc_limit >= 'h67 && !desc_p) |=> (fault_code == 2'd3));

  a_r8_err_index: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (fault_err == $past(req_sel[SEL_W-1:3])));

  a_r9_commit: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (done && fault_code == 2'd0 && wb_type[1] && tr_type == wb_type));

  a_r11_hold_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault_code != 2'd0) |-> (!wb_valid && tr_sel == $past(tr_sel)
                                      && tr_type == $past(tr_type)));

endmodule

bind tr_load_check tr_load_check_sva #(
  .SEL_W(SEL_W), .LIMIT_W(LIMIT_W), .IDX_W(IDX_W)
) u_sva (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
  .fetch_err(fetch_err), .desc_type(desc_type), .desc_s(desc_s),
  .desc_p(desc_p), .desc_limit(desc_limit), .done(done),
  .fault_code(fault_code), .fault_err(fault_err), .wb_valid(wb_valid),
  .wb_type(wb_type), .tr_sel(tr_sel), .tr_type(tr_type)
);

// File: tb/tr_load_check_test.sv
module tr_load_check_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [15:0] req_sel;
  logic        fetch_err;
  logic [3:0]  desc_type;
  logic        desc_s;
  logic        desc_p;
  logic [19:0] desc_limit;
  logic [31:0] desc_base;
  logic [1:0]  desc_dpl;
  logic        done;
  logic [1:0]  fault_code;
  logic [12:0] fault_err;
  logic        wb_valid;
  logic [3:0]  wb_type;
  logic [15:0] tr_sel;
  logic [3:0]  tr_type;
  logic [31:0] tr_base;
  logic [19:0] tr_limit;
  logic [1:0]  tr_dpl;

  int vectors = 0;
  int errors  = 0;
  string tag = "R12";
  bit model_run = 0;

  // reference model state
  int e_done, e_code, e_err, e_wb, e_wbt;
  int e_sel, e_type, e_base, e_limit, e_dpl;

  always #5 clk = ~clk;

  tr_load_check uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
    .fetch_err(fetch_err), .desc_type(desc_type), .desc_s(desc_s),
    .desc_p(desc_p), .desc_limit(desc_limit), .desc_base(desc_base),
    .desc_dpl(desc_dpl), .done(done), .fault_code(fault_code),
    .fault_err(fault_err), .wb_valid(wb_valid), .wb_type(wb_type),
    .tr_sel(tr_sel), .tr_type(tr_type), .tr_base(tr_base),
    .tr_limit(tr_limit), .tr_dpl(tr_dpl)
  );

  function automatic int expect_code(int sel, int fe, int ty, int s, int p, int lim);
    if (fe != 0)                   return 1;  // R1
    if (((sel >> 2) & 1) != 0)     return 1;  // R2
    if (s != 0)                    return 1;  // R3
    if (ty != 1 && ty != 9)        return 1;  // R4
    if (ty == 1 && lim < 'h2B)     return 2;  // R5
    if (ty == 9 && lim < 'h67)     return 2;  // R6
    if (p == 0)                    return 3;  // R7
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_done = 0; e_code = 0; e_err = 0; e_wb = 0; e_wbt = 0;
      e_sel = 0; e_type = 0; e_base = 0; e_limit = 0; e_dpl = 0;
    end else begin
      e_done = req_valid;
      e_code = 0; e_err = 0; e_wb = 0; e_wbt = 0;
      if (req_valid) begin
        e_code = expect_code(req_sel, fetch_err, desc_type, desc_s, desc_p, desc_limit);
        e_err  = req_sel >> 3;
        if (e_code == 0) begin
          e_wb = 1; e_wbt = desc_type | 2;
          e_sel = req_sel; e_type = desc_type | 2; e_base = desc_base;
          e_limit = desc_limit; e_dpl = desc_dpl;
        end
      end
    end
  end

  task automatic cmp(string what, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (model_run) begin
    cmp("done", done, e_done);
    cmp("fault_code", fault_code, e_code);
    cmp("fault_err", fault_err, e_err);
    cmp("wb_valid", wb_valid, e_wb);
    cmp("wb_type", wb_type, e_wbt);
    cmp("tr_sel", tr_sel, e_sel);
    cmp("tr_type", tr_type, e_type);
    cmp("tr_base", tr_base, longint'(unsigned'(e_base)));
    cmp("tr_limit", tr_limit, e_limit);
    cmp("tr_dpl", tr_dpl, e_dpl);
  end

  task automatic idle();
    req_valid = 0; req_sel = 0; fetch_err = 0; desc_type = 0; desc_s = 0;
    desc_p = 0; desc_limit = 0; desc_base = 0; desc_dpl = 0;
  endtask

  task automatic send(string t, logic [15:0] sel, logic fe, logic [3:0] ty,
                      logic s, logic p, logic [19:0] lim, logic [31:0] base,
                      logic [1:0] dpl);
    @(negedge clk);
    tag = t;
    req_valid = 1; req_sel = sel; fetch_err = fe; desc_type = ty; desc_s = s;
    desc_p = p; desc_limit = lim; desc_base = base; desc_dpl = dpl;
    @(negedge clk);
    idle();
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (2) @(negedge clk);
    model_run = 1;       // R12 reset state compared here
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 successful 32-bit load at exact minimum limit (R6 boundary)
    send("R9", 16'h0028, 0, 4'h9, 0, 1, 20'h00067, 32'h1234_5600, 2'd0);
    send("R6", 16'h0030, 0, 4'h9, 0, 1, 20'h00066, 32'hAAAA_0000, 2'd1);
    send("R5", 16'h0038, 0, 4'h1, 0, 1, 20'h0002A, 32'hBBBB_0000, 2'd2);
    send("R5", 16'h0040, 0, 4'h1, 0, 1, 20'h0002B, 32'h0000_8000, 2'd3);
    send("R1", 16'h0048, 1, 4'h9, 0, 1, 20'h00100, 32'hCCCC_0000, 2'd0);
    send("R2", 16'h004C, 0, 4'h9, 0, 1, 20'h00100, 32'hDDDD_0000, 2'd0);
    send("R3", 16'h0050, 0, 4'h9, 1, 1, 20'h00100, 32'hEEEE_0000, 2'd0);
    send("R4", 16'h0058, 0, 4'hB, 0, 1, 20'h00100, 32'hF000_0000, 2'd0);
    send("R4", 16'h0060, 0, 4'h3, 0, 1, 20'h00100, 32'hF100_0000, 2'd0);
    send("R7", 16'h0068, 0, 4'h9, 0, 0, 20'h00100, 32'hF200_0000, 2'd0);
    send("R7", 16'h0070, 0, 4'h9, 0, 0, 20'h00010, 32'hF300_0000, 2'd0);
    send("R7", 16'h0074, 0, 4'h2, 0, 0, 20'h00010, 32'hF300_0000, 2'd0);
    send("R8", 16'hFFF8, 0, 4'h1, 0, 0, 20'hFFFFF, 32'hF400_0000, 2'd0);
    send("R11", 16'h0080, 1, 4'h1, 0, 1, 20'h00100, 32'hF500_0000, 2'd1);
    // R10 back-to-back requests
    @(negedge clk);
    tag = "R10";
    req_valid = 1; req_sel = 16'h0088; desc_type = 4'h9; desc_p = 1;
    desc_limit = 20'h00200; desc_base = 32'h0101_0000; desc_dpl = 2'd2;
    @(negedge clk);
    req_sel = 16'h0090; desc_type = 4'h1; desc_limit = 20'h00010;
    @(negedge clk);
    req_sel = 16'h0098; desc_type = 4'h1; desc_limit = 20'h00030;
    desc_base = 32'h0202_0000;
    @(negedge clk);
    idle();
    repeat (3) @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      send("R9", 16'(i * 8 + (i % 3) * 4), logic'(i % 7 == 0),
           (i % 2) ? 4'h9 : 4'h1, logic'(i % 11 == 5), logic'(i % 5 != 0),
           20'(i * 3), 32'(i * 32'h0001_0101), 2'(i));
    end
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule